// File: doc/BRIEF.md
# Codec Three-Wire Control Register Writer

This block programs the control registers of up to three audio codecs through a shared three-wire serial port. The port has a serial clock, one data line and an active-low select for each codec. For a host request, the block takes a register index and a data byte and forms a 16-bit write command. It pulls low the selects named by a bitmask and shifts the command out, most significant bit first. The codec captures each bit on the rising edge of the serial clock. Setting several mask bits sends the same command to several codecs in one frame.

A built-in bring-up sequencer can run the codec reset and default-configuration writes by itself. Its target is one codec, chosen by a small index, or all codecs together. A request with a mask that names a codec that does not exist is refused, and an error flag reports the refusal. The serial clock speed is set by a parameter that gives the length of each half period in system clock cycles.

Top module: `codec_ctl_writer`

## Requirements
- R1: Out of reset all selects, the serial clock and the data line are high, and busy, done and error are low.
- R2: A host write sends exactly 16 bits, most significant first, one bit captured per rising edge of the serial clock. The frame is {2'b10, 1'b1, index[4:0], data[7:0]}, which equals 16'hA000 | index<<8 | data.
- R3: Select bit n (cs_n[n]) is low for the whole frame when mask bit n is set, and high otherwise. A mask of 4'h7 drives all three selects low together. Outside a write, every select is high.
- R4: The clock and the data line are both low for a half period before any select falls. Data changes only while the clock is low. After the selects rise, the clock and the data line both return high.
- R5: Each clock high phase and each clock low phase lasts CLK_HALF system cycles. A host write keeps busy high for 35*CLK_HALF cycles.
- R6: A host request with a mask above 4'h7 sends nothing and does not raise busy or done. It sets error on the next clock edge.
- R7: A host request that arrives while busy is high has no effect.
- R8: done is high for exactly one cycle at the end of a host write, in the first cycle in which busy is low.
- R9: An init run issues nine writes in this order, as (index, data): (1,00), (2,60), (1,03), (0,07), (3,19), (4,7F), (5,7F), (6,7F), (7,7F).
- R10: With init_all high, an init run uses mask 4'h7. Otherwise the mask is 1<<init_sel. init_sel = 3 gives 4'h8, which is refused: error is set and no frame is sent.
- R11: busy stays high without a gap from the cycle after init_start until the run ends. done pulses once, at the end of the run, and not after each write.
- R12: error stays set until the next start the block accepts. A start is accepted when busy is low. Such a start clears error if its mask is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | Host write request, sampled while busy is low |
| req_mask | input | MASK_W | Codec select bitmask for the host write |
| req_index | input | 5 | Register index for the host write |
| req_data | input | 8 | Register data for the host write |
| init_start | input | 1 | Starts the bring-up sequence; takes priority over req_start |
| init_all | input | 1 | Bring-up targets all codecs |
| init_sel | input | SEL_W | Codec index for a single-codec bring-up |
| cclk | output | 1 | Serial clock to the codecs |
| cdata | output | 1 | Serial data to the codecs |
| cs_n | output | N_CS | Active-low codec selects |
| busy | output | 1 | A write or a bring-up run is in progress |
| done | output | 1 | One-cycle end pulse |
| error | output | 1 | Last accepted request was refused |

## Verification
A host request sampled at edge E raises busy at E+1. busy stays high for 35*CLK_HALF cycles, and done appears in the first cycle after that, together with busy falling. The bench drives inputs and reads outputs one time unit after the falling clock edge, counts busy cycles against that figure and tests done in exactly that cycle and in the cycle after. A refused host mask sets error one edge after the request. A refused bring-up sets error two edges after init_start, because the sequencer spends one cycle issuing its first write. The bench therefore reads error a few cycles later and keeps reading it across an idle gap. The frames themselves are rebuilt by a monitor at the pins from the rising edges of the serial clock. Their content does not depend on the cycle on which they occur.

// File: rtl/codec_ctl_pkg.sv
// Shared constants, types and the command-frame and bring-up-table helpers
// for the codec control writer. Assumes a 5-bit index and 8-bit data field.
package codec_ctl_pkg;

    localparam int FRAME_W    = 16;
    localparam int IDX_W      = 5;
    localparam int DAT_W      = 8;
    localparam int INIT_STEPS = 9;
    localparam int STEP_W     = 4;

    typedef enum logic [2:0] {
        SH_IDLE, SH_PREP, SH_LOW, SH_HIGH, SH_TAIL, SH_REL
    } sh_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAIT
    } sq_state_t;

    // Header 2'b10 (device address) and 1'b1 (write), then index and data.
    function automatic logic [FRAME_W-1:0] make_frame(input logic [IDX_W-1:0] idx,
                                                      input logic [DAT_W-1:0] dat);
        return {3'b101, idx, dat};
    endfunction

    // Register index used by each bring-up step.
    function automatic logic [IDX_W-1:0] step_index(input logic [STEP_W-1:0] s);
        case (s)
            4'd0:    return 5'd1;
            4'd1:    return 5'd2;
            4'd2:    return 5'd1;
            4'd3:    return 5'd0;
            4'd4:    return 5'd3;
            4'd5:    return 5'd4;
            4'd6:    return 5'd5;
            4'd7:    return 5'd6;
            default: return 5'd7;
        endcase
    endfunction

    // Data byte written by each bring-up step.
    function automatic logic [DAT_W-1:0] step_data(input logic [STEP_W-1:0] s);
        case (s)
            4'd0:    return 8'h00;
            4'd1:    return 8'h60;
            4'd2:    return 8'h03;
            4'd3:    return 8'h07;
            4'd4:    return 8'h19;
            default: return 8'h7F;
        endcase
    endfunction

endpackage

// File: rtl/codec_ctl_shifter.sv
// Serialises one 16-bit frame onto the three-wire port.
// Assumes go is only meaningful while idle. A mask above the highest
// existing select is refused through the combinational reject output.
// Sequence: lines low, selects low, 16 clock pulses, selects high, lines high.
module codec_ctl_shifter
    import codec_ctl_pkg::*;
#(
    parameter int N_CS     = 3,
    parameter int MASK_W   = 4,
    parameter int CLK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [MASK_W-1:0]   mask,
    input  logic [FRAME_W-1:0]  frame,
    output logic                reject,
    output logic                active,
    output logic                fin,
    output logic                cclk,
    output logic                cdata,
    output logic [N_CS-1:0]     cs_n
);

    localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [MASK_W-1:0] MASK_MAX = MASK_W'((1 << N_CS) - 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CLK_HALF - 1);

    sh_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [3:0]         bitn;
    logic [FRAME_W-1:0] shreg;
    logic [N_CS-1:0]    sel_q;
    logic               cclk_q, dat_q, fin_q;
    logic [N_CS-1:0]    csn_q;
    logic               idle, mask_ok, accept, phase_end;

    // Request qualification and half-period boundary.
    always_comb begin
        idle      = (state == SH_IDLE);
        mask_ok   = (mask <= MASK_MAX);
        accept    = go && idle && mask_ok;
        reject    = go && idle && !mask_ok;
        phase_end = (cnt == CNT_LAST);
    end

    // Frame sequencing, pin registers and half-period counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            sel_q  <= '0;
            cclk_q <= 1'b1;
            dat_q  <= 1'b1;
            csn_q  <= '1;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!idle) cnt <= phase_end ? '0 : cnt + 1'b1;
            case (state)
                SH_IDLE: if (accept) begin
                    state  <= SH_PREP;
                    cnt    <= '0;
                    bitn   <= '0;
                    shreg  <= frame;
                    sel_q  <= mask[N_CS-1:0];
                    cclk_q <= 1'b0;
                    dat_q  <= 1'b0;
                end
                SH_PREP: if (phase_end) begin
                    state <= SH_LOW;
                    csn_q <= ~sel_q;
                    dat_q <= shreg[FRAME_W-1];
                end
                SH_LOW: if (phase_end) begin
                    state  <= SH_HIGH;
                    cclk_q <= 1'b1;
                end
                SH_HIGH: if (phase_end) begin
                    cclk_q <= 1'b0;
                    if (bitn == 4'(FRAME_W - 1)) begin
                        state <= SH_TAIL;
                    end else begin
                        state <= SH_LOW;
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        dat_q <= shreg[FRAME_W-2];
                    end
                end
                SH_TAIL: if (phase_end) begin
                    state <= SH_REL;
                    csn_q <= '1;
                end
                SH_REL: if (phase_end) begin
                    state  <= SH_IDLE;
                    cclk_q <= 1'b1;
                    dat_q  <= 1'b1;
                    fin_q  <= 1'b1;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign active = !idle;
    assign fin    = fin_q;
    assign cclk   = cclk_q;
    assign cdata  = dat_q;
    assign cs_n   = csn_q;

endmodule

// File: rtl/codec_ctl_initseq.sv
// Walks the nine-step codec bring-up table, issuing one write at a time
// and waiting for each to finish. Assumes trig arrives only while the
// writer is idle. A refused first write ends the run without a done pulse.
module codec_ctl_initseq
    import codec_ctl_pkg::*;
#(
    parameter int MASK_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic [MASK_W-1:0]  mask_in,
    input  logic               wr_fin,
    input  logic               wr_reject,
    output logic               go,
    output logic [MASK_W-1:0]  mask_out,
    output logic [IDX_W-1:0]   idx,
    output logic [DAT_W-1:0]   dat,
    output logic               running,
    output logic               seq_done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(INIT_STEPS - 1);

    sq_state_t         state;
    logic [STEP_W-1:0] step;
    logic [MASK_W-1:0] mask_q;
    logic              done_q;

    // Step walk: issue, wait for completion, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            step   <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SQ_IDLE: if (trig) begin
                    state  <= SQ_ISSUE;
                    step   <= '0;
                    mask_q <= mask_in;
                end
                SQ_ISSUE: state <= wr_reject ? SQ_IDLE : SQ_WAIT;
                SQ_WAIT: if (wr_fin) begin
                    if (step == LAST_STEP) begin
                        state  <= SQ_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= SQ_ISSUE;
                        step  <= step + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign go       = (state == SQ_ISSUE);
    assign mask_out = mask_q;
    assign idx      = step_index(step);
    assign dat      = step_data(step);
    assign running  = (state != SQ_IDLE);
    assign seq_done = done_q;

endmodule

// File: rtl/codec_ctl_writer.sv
// Top of the codec control writer. Chooses between a host write and the
// bring-up sequencer (bring-up wins a tie), builds the frame and keeps the
// error flag. Assumes MASK_W > N_CS so that out-of-range masks exist.
module codec_ctl_writer
    import codec_ctl_pkg::*;
#(
    parameter int N_CS     = 3,
    parameter int MASK_W   = 4,
    parameter int CLK_HALF = 2,
    localparam int SEL_W   = $clog2(N_CS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic [MASK_W-1:0]  req_mask,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [DAT_W-1:0]   req_data,
    input  logic               init_start,
    input  logic               init_all,
    input  logic [SEL_W-1:0]   init_sel,
    output logic               cclk,
    output logic               cdata,
    output logic [N_CS-1:0]    cs_n,
    output logic               busy,
    output logic               done,
    output logic               error
);

    localparam logic [MASK_W-1:0] ALL_MASK = MASK_W'((1 << N_CS) - 1);
    localparam logic [MASK_W-1:0] ONE_MASK = MASK_W'(1);

    logic               sh_go, sh_reject, sh_active, sh_fin;
    logic [MASK_W-1:0]  sh_mask, init_mask, sq_mask;
    logic [FRAME_W-1:0] sh_frame;
    logic               sq_go, sq_running, sq_done;
    logic [IDX_W-1:0]   sq_idx;
    logic [DAT_W-1:0]   sq_dat;
    logic               idle_all, init_go, host_go;
    logic               err_q;

    // Arbitration and source selection for the shifter.
    always_comb begin
        idle_all  = !sh_active && !sq_running;
        init_go   = init_start && idle_all;
        host_go   = req_start && idle_all && !init_start;
        init_mask = init_all ? ALL_MASK : (ONE_MASK << init_sel);
        sh_go     = host_go || sq_go;
        sh_mask   = sq_running ? sq_mask : req_mask;
        sh_frame  = sq_running ? make_frame(sq_idx, sq_dat)
                               : make_frame(req_index, req_data);
    end

    // Error flag: set on a refusal, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (sh_reject)            err_q <= 1'b1;
        else if (init_go || host_go)   err_q <= 1'b0;
    end

    codec_ctl_shifter #(
        .N_CS     (N_CS),
        .MASK_W   (MASK_W),
        .CLK_HALF (CLK_HALF)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sh_go),
        .mask   (sh_mask),
        .frame  (sh_frame),
        .reject (sh_reject),
        .active (sh_active),
        .fin    (sh_fin),
        .cclk   (cclk),
        .cdata  (cdata),
        .cs_n   (cs_n)
    );

    codec_ctl_initseq #(
        .MASK_W (MASK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (init_go),
        .mask_in   (init_mask),
        .wr_fin    (sh_fin),
        .wr_reject (sh_reject),
        .go        (sq_go),
        .mask_out  (sq_mask),
        .idx       (sq_idx),
        .dat       (sq_dat),
        .running   (sq_running),
        .seq_done  (sq_done)
    );

    assign busy  = sh_active || sq_running;
    assign done  = (sh_fin && !sq_running) || sq_done;
    assign error = err_q;

endmodule

// File: rtl/codec_ctl_writer_chk.sv
// Protocol checker for the codec control writer, bound to its top.
// Observes only the top-level pins.
module codec_ctl_writer_chk #(
    parameter int N_CS = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cclk,
    input logic            cdata,
    input logic [N_CS-1:0] cs_n,
    input logic            busy,
    input logic            done
);

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));                                                  // R3

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&$past(cs_n))) |-> $stable(cs_n));                    // R3

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk && $past(cclk)) |-> $stable(cdata));                           // R4

    AST_LINES_LOW_BEFORE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((&$past(cs_n)) && !(&cs_n)) |-> (!$past(cclk) && !$past(cdata)));  // R4

    AST_CLOCK_LOW_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cs_n) && !(&$past(cs_n))) |-> !cclk);                             // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R8

endmodule

bind codec_ctl_writer codec_ctl_writer_chk #(.N_CS(N_CS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cclk  (cclk),
    .cdata (cdata),
    .cs_n  (cs_n),
    .busy  (busy),
    .done  (done)
);

// File: tb/codec_ctl_writer_tb.sv
`timescale 1ns/1ps
module codec_ctl_writer_tb;

    localparam int HALF = 3;
    localparam int WR_CYC = 35 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic [3:0] req_mask = '0;
    logic [4:0] req_index = '0;
    logic [7:0] req_data = '0;
    logic       init_start = 1'b0;
    logic       init_all = 1'b0;
    logic [1:0] init_sel = '0;
    logic       cclk, cdata, busy, done, error;
    logic [2:0] cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    codec_ctl_writer #(.N_CS(3), .MASK_W(4), .CLK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_mask(req_mask),
        .req_index(req_index), .req_data(req_data), .init_start(init_start),
        .init_all(init_all), .init_sel(init_sel), .cclk(cclk), .cdata(cdata),
        .cs_n(cs_n), .busy(busy), .done(done), .error(error)
    );

    // Pin monitor: rebuilds frames from the serial lines.
    logic [15:0] rec_frame [0:31];
    logic [2:0]  rec_mask  [0:31];
    int          rec_bits  [0:31];
    logic        rec_prep  [0:31];
    int   n_rec = 0;
    int   n_done = 0;
    int   stable_viol = 0;
    logic p_cclk = 1'b1, p_dat = 1'b1;
    logic [2:0] p_cs = 3'b111;
    logic [15:0] cur;
    logic [2:0]  cur_mask;
    int          cur_bits;
    logic        cur_prep;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) n_done++;
            if (cs_n != 3'b111 && p_cs == 3'b111) begin
                cur = '0; cur_bits = 0; cur_mask = ~cs_n;
                cur_prep = (p_cclk == 1'b0 && p_dat == 1'b0 && cclk == 1'b0);
            end
            if (cs_n != 3'b111 && cclk && !p_cclk) begin
                cur = {cur[14:0], cdata}; cur_bits++;
            end
            if (cclk && p_cclk && cdata != p_dat) stable_viol++;
            if (cs_n == 3'b111 && p_cs != 3'b111 && n_rec < 32) begin
                rec_frame[n_rec] = cur; rec_mask[n_rec] = cur_mask;
                rec_bits[n_rec] = cur_bits; rec_prep[n_rec] = cur_prep;
                n_rec++;
            end
        end
        p_cclk = cclk; p_dat = cdata; p_cs = cs_n;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    task automatic t_reset();
        check("R1 cs_n", cs_n, 3'b111);
        check("R1 cclk", cclk, 1);
        check("R1 cdata", cdata, 1);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 error", error, 0);
    endtask

    task automatic t_write(input logic [3:0] m, input logic [4:0] idx, input logic [7:0] d);
        int base = n_rec;
        int cyc = 0;
        logic [15:0] exp = 16'hA000 | (16'(idx) << 8) | 16'(d);
        req_mask = m; req_index = idx; req_data = d; req_start = 1'b1;
        step();
        req_start = 1'b0;
        while (busy && cyc < 10000) begin cyc++; step(); end
        check("R5 busy length", cyc, WR_CYC);
        check("R8 done at end", done, 1);
        check("R4 lines idle high", {cclk, cdata}, 2'b11);
        step();
        check("R8 done single", done, 0);
        check("R2 frame count", n_rec - base, 1);
        check("R2 frame bits", rec_bits[base], 16);
        check("R2 frame value", rec_frame[base], exp);
        check("R3 select mask", rec_mask[base], m[2:0]);
        check("R4 lines low before select", rec_prep[base], 1);
        check("R4 data stable while clock high", stable_viol, 0);
        check("R12 error clear after valid", error, 0);
    endtask

    task automatic t_half_period();
        int lo = 0;
        int hi = 0;
        req_mask = 4'h1; req_index = 5'd9; req_data = 8'h3C; req_start = 1'b1;
        step();
        req_start = 1'b0;
        while (cs_n == 3'b111) step();
        while (!cclk) begin lo++; step(); end
        while (cclk) begin hi++; step(); end
        check("R5 clock low phase", lo, HALF);
        check("R5 clock high phase", hi, HALF);
        while (busy) step();
        step();
    endtask

    task automatic t_reject();
        int base = n_rec;
        int d0 = n_done;
        req_mask = 4'h9; req_index = 5'd2; req_data = 8'h55; req_start = 1'b1;
        step();
        req_start = 1'b0;
        check("R6 error set", error, 1);
        check("R6 no busy", busy, 0);
        repeat (20) step();
        check("R6 no frame", n_rec - base, 0);
        check("R6 no done", n_done - d0, 0);
        check("R12 error held", error, 1);
    endtask

    task automatic t_busy_ignore();
        int base = n_rec;
        req_mask = 4'h1; req_index = 5'd2; req_data = 8'h11; req_start = 1'b1;
        step();
        req_start = 1'b0;
        repeat (10) step();
        req_mask = 4'h2; req_index = 5'd3; req_data = 8'h22; req_start = 1'b1;
        step();
        req_start = 1'b0;
        while (busy) step();
        repeat (30) step();
        check("R7 one frame only", n_rec - base, 1);
        check("R7 first frame kept", rec_frame[base], 16'hA211);
        check("R7 first mask kept", rec_mask[base], 3'b001);
        check("R7 idle after", busy, 0);
    endtask

    task automatic t_init(input logic all, input logic [1:0] sel, input logic [2:0] m);
        logic [15:0] exp [0:8] = '{16'hA100, 16'hA260, 16'hA103, 16'hA007, 16'hA319,
                                   16'hA47F, 16'hA57F, 16'hA67F, 16'hA77F};
        int base = n_rec;
        int d0 = n_done;
        int cyc = 0;
        int gaps = 0;
        init_all = all; init_sel = sel; init_start = 1'b1;
        step();
        init_start = 1'b0;
        while (!done && cyc < 20000) begin
            if (!busy) gaps++;
            cyc++; step();
        end
        check("R11 busy without gap", gaps, 0);
        check("R11 done at end", done, 1);
        check("R11 not busy at done", busy, 0);
        step();
        check("R11 single done", n_done - d0, 1);
        check("R9 write count", n_rec - base, 9);
        for (int i = 0; i < 9; i++) begin
            check($sformatf("R9 step %0d frame", i), rec_frame[base + i], exp[i]);
            check($sformatf("R10 step %0d mask", i), rec_mask[base + i], m);
        end
    endtask

    task automatic t_init_reject();
        int base = n_rec;
        int d0 = n_done;
        init_all = 1'b0; init_sel = 2'd3; init_start = 1'b1;
        step();
        init_start = 1'b0;
        repeat (3) step();
        check("R10 refused init error", error, 1);
        check("R10 refused init idle", busy, 0);
        repeat (20) step();
        check("R10 refused init no frame", n_rec - base, 0);
        check("R10 refused init no done", n_done - d0, 0);
        check("R12 error persists", error, 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write(4'h1, 5'd5, 8'hA5);
        t_write(4'h7, 5'd31, 8'h00);
        t_write(4'h4, 5'd0, 8'hFF);
        t_half_period();
        t_reject();
        t_write(4'h2, 5'd17, 8'h96);
        t_busy_ignore();
        t_init(1'b1, 2'd0, 3'b111);
        t_init(1'b0, 2'd1, 3'b010);
        t_init_reject();
        t_write(4'h3, 5'd4, 8'h5A);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule